// File: doc/BRIEF.md
# Serial-In Shift Register with Parallel Holding Latch

This block turns a serial bit stream into a parallel word. Bits enter a chain of `WIDTH` stages, one stage per rising edge of a dedicated shift clock. A second, independent storage clock copies the whole chain into a holding register, and only that register reaches the parallel outputs. The parallel outputs can therefore stay steady while a new word is shifted in, and all of them change together when the storage clock pulses.

An active-low clear empties the shift chain at once, with no clock edge needed, and leaves the holding register as it is. An active-low output enable either drives the held word onto the parallel pins or lets them float. The raw held word and the drive enable are also brought out separately, so the block can sit inside a device that has no internal tri-state buses. The last stage of the chain drives a cascade output. Feeding that output into the serial input of another unit, with both units on the same two clocks, gives a longer register.

Top module: `sipo_latch_top`

## Requirements
- R1: On every rising edge of `shift_clk` while `clr_n` is high, `ser_in` is captured into stage 0 and each stage i takes the old value of stage i-1. Parallel bit i corresponds to stage i.
- R2: On a rising edge of `store_clk`, all stages are copied into the holding register (`par_data`). Shift edges without a storage edge leave `par_data` unchanged.
- R3: When `shift_clk` and `store_clk` rise at the same instant, the holding register captures the chain contents as they were before that shift.
- R4: Driving `clr_n` low forces every stage to 0 immediately, without any clock edge, and `casc_out` reads 0 while the clear is held.
- R5: With `oe_n` low, `par_drive` is 1 and `par_q` equals `par_data`. With `oe_n` high, `par_drive` is 0 and `par_q` floats (all bits high-impedance), while `par_data` still shows the held word.
- R6: `casc_out` always equals the last stage (stage `WIDTH-1`). It is not changed by storage edges or by `oe_n`.
- R7: The clear leaves the holding register unchanged. Zeros appear on `par_data` only after a later `store_clk` edge.
- R8: Two units chained through `casc_out` with shared clocks, after 16 shift edges and one storage edge, hold the first eight bits shifted in the downstream unit (first bit at bit 7) and the last eight in the upstream unit (last bit at bit 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift chain clock, rising edge |
| store_clk | input | 1 | Holding register clock, rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| par_q | output | WIDTH | Tri-state parallel outputs |
| par_data | output | WIDTH | Holding register contents, always driven |
| par_drive | output | 1 | High when par_q is driven |
| casc_out | output | 1 | Last shift stage, used for chaining |

## Verification
The shift edge and the storage edge can land in the same instant. The bench causes this by raising both clocks in one statement for a run of bits. It then expects the parallel word to match a model snapshot taken before that shift. A second overlap is the clear arriving partway through a cycle while a word is held. There the cascade output must read 0 at once and the held word must stay unchanged until the next storage edge.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    typedef enum logic {
        PAR_FLOAT = 1'b0,
        PAR_DRIVE = 1'b1
    } par_mode_e;

    function automatic par_mode_e decode_oe(input logic oe_n);
        return oe_n ? PAR_FLOAT : PAR_DRIVE;
    endfunction

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             shift_clk,
    input  logic             clr_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages,
    output logic             tail_bit
);

    typedef struct packed {
        logic [WIDTH-1:0] stg;
    } chain_t;

    chain_t chain_q, chain_d;

    always_comb begin
        chain_d        = chain_q;
        chain_d.stg[0] = ser_in;
        for (int i = 1; i < WIDTH; i++) begin
            chain_d.stg[i] = chain_q.stg[i-1];
        end
    end

    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign stages   = chain_q.stg;
    assign tail_bit = chain_q.stg[WIDTH-1];

    // Set after one clean shift edge; dropped by any clear in between.
    logic armed_q;
    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_shift_step_R1: assert property (@(posedge shift_clk) disable iff (!clr_n)
        armed_q |-> (chain_q.stg[0] == $past(ser_in)) &&
                    (chain_q.stg[WIDTH-1:1] == $past(chain_q.stg[WIDTH-2:0])));

    assert_tail_follow_R6: assert property (@(posedge shift_clk) disable iff (!clr_n)
        armed_q |-> (tail_bit == $past(chain_q.stg[WIDTH-2])));

    assert_clear_empties_R4: assert property (@(posedge shift_clk)
        !clr_n |=> (stages == '0) && (tail_bit == 1'b0));

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
    parameter int WIDTH = 8
) (
    input  logic             store_clk,
    input  logic [WIDTH-1:0] snap,
    output logic [WIDTH-1:0] held
);

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } hold_t;

    hold_t hold_q, hold_d;

    always_comb begin
        hold_d     = hold_q;
        hold_d.val = snap;
    end

    always_ff @(posedge store_clk) begin
        hold_q <= hold_d;
    end

    assign held = hold_q.val;

endmodule

// File: rtl/sipo_out_stage.sv
module sipo_out_stage #(
    parameter int WIDTH = 8
) (
    input  logic             oe_n,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] out_data,
    output logic             out_en
);
    import sipo_pkg::*;

    par_mode_e mode_d;

    always_comb begin
        mode_d   = decode_oe(oe_n);
        out_en   = (mode_d == PAR_DRIVE);
        out_data = held;
    end

endmodule

// File: rtl/sipo_latch_top.sv
module sipo_latch_top #(
    parameter int WIDTH = 8
) (
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             store_clk,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_q,
    output logic [WIDTH-1:0] par_data,
    output logic             par_drive,
    output logic             casc_out
);

    logic [WIDTH-1:0] stages_w;
    logic [WIDTH-1:0] held_w;

    sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .shift_clk (shift_clk),
        .clr_n     (clr_n),
        .ser_in    (ser_in),
        .stages    (stages_w),
        .tail_bit  (casc_out)
    );

    sipo_hold_reg #(.WIDTH(WIDTH)) u_hold (
        .store_clk (store_clk),
        .snap      (stages_w),
        .held      (held_w)
    );

    sipo_out_stage #(.WIDTH(WIDTH)) u_out (
        .oe_n     (oe_n),
        .held     (held_w),
        .out_data (par_data),
        .out_en   (par_drive)
    );

    assign par_q = par_drive ? par_data : {WIDTH{1'bz}};

    assert_float_when_off_R5: assert property (@(posedge shift_clk) disable iff (!clr_n)
        oe_n |-> (par_drive == 1'b0));

    assert_drive_when_on_R5: assert property (@(posedge shift_clk) disable iff (!clr_n)
        !oe_n |-> (par_drive == 1'b1) && (par_q == par_data));

endmodule

// File: tb/sipo_latch_top_tb.sv
module sipo_latch_top_tb_top;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz reference

    logic       ser_in = 1'b0, shift_clk = 1'b0, store_clk = 1'b0;
    logic       clr_n = 1'b0, oe_n = 1'b1;
    wire  [7:0] par_q, tail_par_q;
    logic [7:0] par_data, tail_par_data;
    logic       par_drive, tail_par_drive, casc_out, tail_casc;

    sipo_latch_top #(.WIDTH(8)) dut_i (
        .ser_in(ser_in), .shift_clk(shift_clk), .store_clk(store_clk),
        .clr_n(clr_n), .oe_n(oe_n), .par_q(par_q), .par_data(par_data),
        .par_drive(par_drive), .casc_out(casc_out)
    );

    sipo_latch_top #(.WIDTH(8)) tail_i (
        .ser_in(casc_out), .shift_clk(shift_clk), .store_clk(store_clk),
        .clr_n(clr_n), .oe_n(oe_n), .par_q(tail_par_q), .par_data(tail_par_data),
        .par_drive(tail_par_drive), .casc_out(tail_casc)
    );

    // Model: [7:0] upstream stages, [15:8] downstream stages.
    logic [15:0] mdl_sr = '0;
    logic [15:0] mdl_hold = '0;
    int vectors = 0;
    int fails = 0;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk) ser_in = b;
        @(posedge clk) shift_clk = 1'b1;
        mdl_sr = {mdl_sr[14:0], b};
        @(negedge clk) shift_clk = 1'b0;
    endtask

    task automatic store_pulse();
        @(posedge clk) store_clk = 1'b1;
        mdl_hold = mdl_sr;
        @(negedge clk) store_clk = 1'b0;
    endtask

    task automatic tied_bit(input logic b);
        @(negedge clk) ser_in = b;
        @(posedge clk) begin shift_clk = 1'b1; store_clk = 1'b1; end
        mdl_hold = mdl_sr;
        mdl_sr   = {mdl_sr[14:0], b};
        @(negedge clk) begin shift_clk = 1'b0; store_clk = 1'b0; end
    endtask

    task automatic check_state(input string req);
        #2;
        check(req, {8'h0, par_data}, {8'h0, mdl_hold[7:0]});
        check(req, {15'h0, casc_out}, {15'h0, mdl_sr[7]});
        if (!oe_n) begin
            check(req, {15'h0, par_drive}, 16'h1);
            check(req, {8'h0, par_q}, {8'h0, mdl_hold[7:0]});
        end
    endtask

    task automatic t_reset();
        #3;
        check("R4 reset casc", {15'h0, casc_out}, 16'h0);
        store_pulse();
        #2;
        check("R2 reset hold", {8'h0, par_data}, 16'h0);
        @(negedge clk) clr_n = 1'b1;
        oe_n = 1'b0;
        check_state("R5 reset drive");
    endtask

    task automatic t_shift();
        logic [7:0] w = 8'hA5;
        for (int i = 7; i >= 0; i--) begin
            shift_bit(w[i]);
            check_state("R1 R6 shift step");
        end
        store_pulse();
        check_state("R2 store A5");
        check("R1 order", {8'h0, par_data}, 16'h00A5);
    endtask

    task automatic t_isolation();
        shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1);
        check_state("R2 hold during shifts");
        store_pulse();
        check_state("R6 store leaves casc");
    endtask

    task automatic t_oe();
        @(negedge clk) oe_n = 1'b1;
        #2 check("R5 float", {15'h0, par_drive}, 16'h0);
        shift_bit(1'b1);
        check_state("R6 casc with oe off");
        store_pulse();
        check_state("R5 data while floating");
        @(negedge clk) oe_n = 1'b0;
        check_state("R5 reenable");
    endtask

    task automatic t_clear();
        for (int i = 0; i < 8; i++) shift_bit(1'b1);
        store_pulse();
        check_state("R2 all ones");
        @(posedge clk) #3 clr_n = 1'b0;
        mdl_sr = '0;
        #2;
        check("R4 casc drops", {15'h0, casc_out}, 16'h0);
        check("R7 hold kept", {8'h0, par_data}, 16'h00FF);
        #5 clr_n = 1'b1;
        shift_bit(1'b0);
        check_state("R7 still held");
        store_pulse();
        check_state("R7 zeros after store");
    endtask

    task automatic t_tied();
        logic [7:0] w = 8'h3C;
        for (int i = 7; i >= 0; i--) begin
            tied_bit(w[i]);
            check_state("R3 tied clocks");
        end
    endtask

    task automatic t_chain();
        logic [15:0] w = 16'hC35A;
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
        store_pulse();
        #2;
        check("R8 upstream", {8'h0, par_data}, {8'h0, w[7:0]});
        check("R8 downstream", {8'h0, tail_par_data}, {8'h0, w[15:8]});
        check("R8 downstream pins", {8'h0, tail_par_q}, {8'h0, mdl_hold[15:8]});
        check("R8 tail casc", {15'h0, tail_casc}, {15'h0, mdl_sr[15]});
    endtask

    initial begin
        t_reset();
        t_shift();
        t_isolation();
        t_oe();
        t_clear();
        t_tied();
        t_chain();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule